// File: doc/BRIEF.md
# Granular Strand Pause Timer

This block stalls one hardware thread for a requested number of clock cycles. Software writes a cycle count to the pause port. The block drops the three least significant bits of that count and keeps the rest in a coarse counter. The counter steps down by one after each full granule of 8 clock cycles. While the counter is non-zero the stall output is high. The stall starts in the cycle after the write, and it ends when the counter runs out.

A count below 8 gives the smallest possible pause of one cycle. A disrupting event, such as an interrupt or trap, can arrive from another clock domain. It passes through a parameterised synchronizer and then cancels a running pause at once. A new write while a pause is running replaces the remaining time and starts a fresh granule. A one-cycle done pulse marks the first idle cycle after a pause ends, whether the counter ran out or the pause was cancelled.

Top module: `strand_pause_timer`

## Requirements
- R1: A write (`wr_valid` high at a clock edge) makes `stall` high from the next cycle.
- R2: For a written value V >= 8, `stall` stays high for exactly 8*floor(V/8) consecutive cycles. Bits [2:0] of V do not change the length.
- R3: For a written value V < 8 (including 0), `stall` is high for exactly one cycle.
- R4: `done` is high for exactly one cycle, namely the first cycle with `stall` low after a pause ends. It is low at every other time.
- R5: A write during an active pause reloads the counter from the new value and restarts the 8-cycle granule. The new pause length counts from that write as in R2/R3, and no `done` pulse is produced by the reload.
- R6: `trap_async` high for one clock edge ends an active pause. `stall` is low, and `done` is high, SYNC_STAGES+1 cycles after the cycle in which the trap was sampled.
- R7: A trap while no pause is active has no effect: `stall` and `done` stay low.
- R8: When a write and a synchronized trap meet in the same cycle, the write wins and the pause is started. A trap that is still present in the following cycle then ends it.
- R9: During and right after reset, `stall` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| wr_valid | input | 1 | Pause register write strobe |
| wr_data | input | DATA_W | Requested pause length in cycles |
| trap_async | input | 1 | Disrupting event, asynchronous to clk |
| stall | output | 1 | Thread held while high |
| done | output | 1 | One-cycle pulse when a pause ends |

## Verification
The hardest case to reach is the collision between a write and a trap. The trap only reaches the counter after the synchronizer delay, so the two cannot be lined up simply by driving both pins in the same cycle. The bench holds the trap line high across several cycles and then issues a write. The synchronized trap is therefore present in the write cycle and the cycle after it, which checks both that the write wins and that the follow-on abort happens. The trap-abort case is timed against the exact synchronizer depth, and the reload case is timed in the middle of a long pause, so that a granule-restart bug changes the measured length.

// File: rtl/pause_pkg.sv
package pause_pkg;
    // Number of low bits folded into one counter step (granule = 2**GRAN_BITS cycles)
    localparam int GRAN_BITS = 3;
    localparam int GRAN_CYCLES = 1 << GRAN_BITS;
endpackage

// File: rtl/pause_trap_sync.sv
module pause_trap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_out = async_in;
        end else begin : g_chain
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-1:0], async_in} >> 0;
                if (STAGES > 1) begin
                    chain_d = {chain_q, async_in} >> 0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign sync_out = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pause_granule.sv
module pause_granule
    import pause_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [GRAN_BITS-1:0] restart_val,
    input  logic                 run,
    output logic                 tick
);
    typedef struct packed {
        logic [GRAN_BITS-1:0] phase;
    } gran_state_t;

    gran_state_t st_d, st_q;

    assign tick = run && (st_q.phase == {GRAN_BITS{1'b1}});

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.phase = restart_val;
        end else if (run) begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: after the last phase of a granule the next granule starts at phase zero
    p_granule_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (st_q.phase == '0));

    // R5: a restart lands on the requested phase
    p_granule_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.phase == $past(restart_val)));
endmodule

// File: rtl/pause_counter.sv
module pause_counter #(
    parameter int CNT_W = 61
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             abort,
    output logic             active,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (load) begin
            st_d.cnt    = load_val;
            st_d.active = (load_val != '0);
        end else if (st_q.active && abort) begin
            st_d.cnt    = '0;
            st_d.active = 1'b0;
            st_d.done   = 1'b1;
        end else if (st_q.active && tick) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign done   = st_q.done;

    // R4: the done pulse lasts one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R4: done only follows a cycle that was stalled
    p_done_after_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.active && $past(st_q.active)));

    // R5: a reload never produces a done pulse
    p_reload_no_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !st_q.done);

    // R6: an abort of a running pause clears it in one edge
    p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && st_q.active && !load) |=> (!st_q.active && st_q.done));
endmodule

// File: rtl/strand_pause_timer.sv
module strand_pause_timer
    import pause_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trap_async,
    output logic              stall,
    output logic              done
);
    localparam int CNT_W = DATA_W - GRAN_BITS;

    logic                 trap_s;
    logic                 tick;
    logic                 is_short;
    logic [CNT_W-1:0]     load_cnt;
    logic [GRAN_BITS-1:0] load_phase;

    // Values below one granule: one count, started on the last phase -> one cycle
    always_comb begin
        is_short   = (wr_data < DATA_W'(GRAN_CYCLES));
        load_cnt   = is_short ? CNT_W'(1) : wr_data[DATA_W-1:GRAN_BITS];
        load_phase = is_short ? {GRAN_BITS{1'b1}} : '0;
    end

    pause_trap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trap_async),
        .sync_out (trap_s)
    );

    pause_granule u_gran (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (wr_valid),
        .restart_val (load_phase),
        .run         (stall),
        .tick        (tick)
    );

    pause_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_valid),
        .load_val (load_cnt),
        .tick     (tick),
        .abort    (trap_s),
        .active   (stall),
        .done     (done)
    );

    // R1: a write stalls the thread from the next cycle
    p_write_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> stall);

    // R3: a short write releases after one stalled cycle
    p_short_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && is_short) ##1 !wr_valid |=> !stall);

    // R6: a synchronized trap ends a running pause
    p_trap_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_s && stall && !wr_valid) |=> (!stall && done));

    // R7: with no pause and no write, no done can follow
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !wr_valid) |=> (!done && !stall));
endmodule

// File: tb/tb_strand_pause_timer.sv
module tb_strand_pause_timer;
    localparam int DW = 64;
    localparam int SYNC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          trap_async = 1'b0;
    logic          stall;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    strand_pause_timer #(.DATA_W(DW), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .trap_async(trap_async), .stall(stall), .done(done)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one write; returns at the negedge of the first cycle after it
    task automatic do_write(input logic [DW-1:0] v);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = v;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Count stalled cycles from now, then check done in the first idle cycle
    task automatic measure(input string req, input int exp_len);
        int len = 0;
        int done_early = 0;
        while (stall && len < 5000) begin
            if (done) done_early++;
            len++;
            @(negedge clk);
        end
        chk(req, len, exp_len);
        chk("R4 done during stall", done_early, 0);
        chk("R4 done at end", done, 1);
        @(negedge clk);
        chk("R4 done single cycle", done, 0);
    endtask

    task automatic t_reset;
        chk("R9 stall in reset", stall, 0);
        chk("R9 done in reset", done, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R9 stall after reset", stall, 0);
        chk("R9 done after reset", done, 0);
    endtask

    task automatic t_lengths;
        do_write(64'd8);   chk("R1 stall after write", stall, 1); measure("R2 len 8", 8);
        do_write(64'd15);  measure("R2 low bits ignored", 8);
        do_write(64'd100); measure("R2 len 100", 96);
        do_write(64'd7);   measure("R3 len 7", 1);
        do_write(64'd0);   measure("R3 len 0", 1);
    endtask

    task automatic t_reload;
        int seen_done = 0;
        do_write(64'd64);
        for (int i = 0; i < 20; i++) begin
            if (done) seen_done++;
            @(negedge clk);
        end
        chk("R5 still stalled", stall, 1);
        do_write(64'd16);
        chk("R5 no done on reload", done | seen_done, 0);
        measure("R5 reload length", 16);
        do_write(64'd800);
        repeat (13) @(negedge clk);
        do_write(64'd3);
        measure("R5 reload to short", 1);
    endtask

    task automatic t_trap_abort;
        do_write(64'd800);
        repeat (10) @(negedge clk);
        trap_async = 1'b1;
        @(negedge clk);
        trap_async = 1'b0;
        for (int k = 1; k < SYNC; k++) begin
            chk("R6 stall before sync delay", stall, 1);
            @(negedge clk);
        end
        chk("R6 stall during sync delay", stall, 1);
        @(negedge clk);
        chk("R6 stall after trap", stall, 0);
        chk("R6 done after trap", done, 1);
        @(negedge clk);
        chk("R6 done single", done, 0);
    endtask

    task automatic t_trap_idle;
        int bad = 0;
        @(negedge clk);
        trap_async = 1'b1;
        @(negedge clk);
        trap_async = 1'b0;
        for (int i = 0; i < SYNC + 4; i++) begin
            if (stall || done) bad++;
            @(negedge clk);
        end
        chk("R7 idle trap ignored", bad, 0);
    endtask

    task automatic t_collision;
        @(negedge clk);
        trap_async = 1'b1;
        repeat (SYNC + 2) @(negedge clk);
        do_write(64'd800);
        chk("R8 write wins", stall, 1);
        @(negedge clk);
        chk("R8 trap then ends", stall, 0);
        chk("R8 done after abort", done, 1);
        trap_async = 1'b0;
        repeat (SYNC + 2) @(negedge clk);
        chk("R8 quiet after", stall | done, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                t_lengths();
                t_reload();
                t_trap_abort();
                t_trap_idle();
                t_collision();
            end
            begin
                wait (cycles >= 200000);
                checks++; fails++;
                $display("FAIL watchdog actual=%0d expected=<200000", cycles);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule